// File: doc/BRIEF.md
# Table-Pointer ROM Checksum Engine

This block computes a 16-bit additive signature over every word of a program ROM in a machine with separate program and data memories. In such a machine the processor cannot fetch instruction words as data. A dedicated table counter therefore steps through the ROM on its own, apart from any program counter. For every location, the engine reads the running sum from two bytes of the data RAM. It then fetches the ROM word at the table counter, adds it, and writes the new sum back to the same two bytes.

A run begins with a one-cycle start request. The engine first zeroes the two sum bytes. It then walks the table counter from 0 up to its last value, where the counter wraps back to 0. At the end of the run it raises done and compares the final sum with the signature that was captured when the start was accepted. The RAM and ROM sit outside the block. Both have a synchronous read with a latency of one cycle.

Top module: `rom_csum_engine`

## Requirements
- R1: After a synchronous reset, busy_o, done_o, mismatch_o, rom_rd_o, ram_rd_o and ram_wr_o are all low.
- R2: Within a run, rom_rd_o pulses exactly once for each ROM address, in ascending order 0, 1, ..., 2^ROM_AW-1. rom_addr_o does not change in the cycle after a ROM read.
- R3: The signature is the sum of all ROM words, zero-extended to 16 bits and taken modulo 2^16. The low byte is stored at RAM address SUM_BASE and the high byte at SUM_BASE+1. After each address, the two stored bytes equal the running sum up to and including that address.
- R4: Each address takes seven cycles in this order: RAM read of the low byte, RAM read of the high byte, ROM read, add, low-byte write, high-byte write, advance. busy_o is high for exactly 2 + 7*2^ROM_AW cycles per run.
- R5: Before the first ROM read of a run, two RAM writes of value 0 go first to SUM_BASE and then to SUM_BASE+1. The result therefore does not depend on the earlier RAM contents.
- R6: done_o rises in the same cycle that busy_o falls. mismatch_o is 1 exactly when the final sum differs from expect_sig_i as sampled on the clock edge that accepted start. Both flags stay unchanged until the next accepted start.
- R7: A start_i pulse while busy_o is high is ignored. The run length and the result are unchanged.
- R8: An accepted start clears done_o and mismatch_o on the next cycle.
- R9: RAM writes go only to SUM_BASE or SUM_BASE+1, and a RAM read and a RAM write never occur in the same cycle. Each run makes 2 + 2*2^ROM_AW writes.
- R10: The table counter wraps from its last value to 0 at the end of a run, so every later run starts again at ROM address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when idle |
| expect_sig_i | input | 2*RAM_DW | Expected signature, captured at start |
| rom_addr_o | output | ROM_AW | ROM address from the table counter |
| rom_rd_o | output | 1 | ROM read strobe; data is returned on the next cycle |
| rom_data_i | input | ROM_DW | ROM read data |
| ram_addr_o | output | RAM_AW | RAM byte address |
| ram_rd_o | output | 1 | RAM read strobe; data is returned on the next cycle |
| ram_wr_o | output | 1 | RAM write strobe |
| ram_wdata_o | output | RAM_DW | RAM write data |
| ram_rdata_i | input | RAM_DW | RAM read data |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until the next start |
| mismatch_o | output | 1 | Final sum differs from the captured signature |

## Verification
A corrupted sequencer state shows up at once as a wrong strobe pattern on the RAM and ROM ports within the seven-cycle slot of the address concerned. A wrong table counter value shows up at the next ROM read as an address out of order. A wrong byte capture or a wrong adder result appears at the high-byte write of the same address, two cycles after the add, because each stored pair is compared with a running sum kept in the bench. A fault in the flags or in the signature capture shows only at the end of a run, in done_o and mismatch_o.

// File: rtl/rcs_pkg.sv
// Package for the ROM checksum engine: sequencer states, the select for the
// RAM write data, and the control word the sequencer sends to the datapath.
package rcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CLR_LO,
        ST_CLR_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_ROM_RD,
        ST_ADD,
        ST_WR_LO,
        ST_WR_HI,
        ST_NEXT
    } rcs_state_e;

    typedef enum logic [1:0] {
        WD_ZERO,
        WD_LO,
        WD_HI
    } rcs_wsel_e;

    typedef struct packed {
        logic      clr_cnt;
        logic      inc_cnt;
        logic      cap_lo;
        logic      cap_hi;
        logic      cap_add;
        logic      latch_exp;
        logic      sel_hi;
        rcs_wsel_e wsel;
    } rcs_ctrl_t;

endpackage

// File: rtl/rcs_table_counter.sv
// Table counter: holds the ROM address used for checksum reads. It is
// separate from any program counter.
// Assumes: clr and inc are never high together. inc wraps the counter
// naturally from all-ones back to zero.
module rcs_table_counter #(
    parameter int AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          inc_i,
    output logic [AW-1:0] cnt_o,
    output logic          last_o
);

    localparam logic [AW-1:0] CNT_MAX = {AW{1'b1}};

    logic [AW-1:0] cnt_q;

    // Purpose: clear at start, advance by one after each address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_MAX);

    // R10: advancing from the last address returns the counter to zero
    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && last_o) |=> (cnt_o == '0));

endmodule

// File: rtl/rcs_sum_datapath.sv
// Sum datapath: captures the two partial-sum bytes that come back from RAM,
// adds the zero-extended ROM word modulo 2^SUM_W, selects the RAM write
// byte, and compares the held sum with the signature captured at start.
// Assumes: ROM_DW <= 2*RAM_DW, and read data is valid in the cycle after
// its strobe.
module rcs_sum_datapath
    import rcs_pkg::*;
#(
    parameter int ROM_DW = 14,
    parameter int RAM_DW = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  rcs_ctrl_t             ctrl_i,
    input  logic [RAM_DW-1:0]     ram_rdata_i,
    input  logic [ROM_DW-1:0]     rom_data_i,
    input  logic [2*RAM_DW-1:0]   expect_sig_i,
    output logic [RAM_DW-1:0]     wdata_o,
    output logic                  sum_neq_o
);

    localparam int SUM_W = 2 * RAM_DW;
    localparam int PAD_W = SUM_W - ROM_DW;

    logic [RAM_DW-1:0] acc_lo_q;
    logic [RAM_DW-1:0] acc_hi_q;
    logic [SUM_W-1:0]  sum_q;
    logic [SUM_W-1:0]  exp_q;
    logic [SUM_W-1:0]  rom_ext;

    assign rom_ext = {{PAD_W{1'b0}}, rom_data_i};

    // Purpose: capture the partial-sum bytes as they return from RAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_lo_q <= '0;
            acc_hi_q <= '0;
        end else begin
            if (ctrl_i.cap_lo) acc_lo_q <= ram_rdata_i;
            if (ctrl_i.cap_hi) acc_hi_q <= ram_rdata_i;
        end
    end

    // Purpose: form the new partial sum; the adder wraps modulo 2^SUM_W.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (ctrl_i.clr_cnt) begin
            sum_q <= '0;
        end else if (ctrl_i.cap_add) begin
            sum_q <= {acc_hi_q, acc_lo_q} + rom_ext;
        end
    end

    // Purpose: hold the expected signature for the whole run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else if (ctrl_i.latch_exp) begin
            exp_q <= expect_sig_i;
        end
    end

    // Purpose: choose the byte written to RAM.
    always_comb begin
        case (ctrl_i.wsel)
            WD_LO:   wdata_o = sum_q[RAM_DW-1:0];
            WD_HI:   wdata_o = sum_q[SUM_W-1:RAM_DW];
            default: wdata_o = '0;
        endcase
    end

    assign sum_neq_o = (sum_q != exp_q);

    // R3: the sum changes only on an add or on the clear at start
    a_r3_sum_only_on_add: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_i.cap_add && !ctrl_i.clr_cnt) |=> $stable(sum_q));

endmodule

// File: rtl/rcs_seq_fsm.sv
// Sequencer: runs the clear step, then the seven-step read-add-write slot
// for each ROM address, and drives the memory strobes and result flags.
// Assumes: last_i is high while the table counter holds its final address.
module rcs_seq_fsm
    import rcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       last_i,
    input  logic       sum_neq_i,
    output rcs_state_e state_o,
    output rcs_ctrl_t  ctrl_o,
    output logic       rom_rd_o,
    output logic       ram_rd_o,
    output logic       ram_wr_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       mismatch_o
);

    rcs_state_e state_q;
    rcs_state_e state_d;
    logic       done_q;
    logic       mism_q;
    logic       accept;

    assign accept = (state_q == ST_IDLE) && start_i;

    // Purpose: pick the next step of the sequence.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_CLR_LO;
            ST_CLR_LO: state_d = ST_CLR_HI;
            ST_CLR_HI: state_d = ST_RD_LO;
            ST_RD_LO:  state_d = ST_RD_HI;
            ST_RD_HI:  state_d = ST_ROM_RD;
            ST_ROM_RD: state_d = ST_ADD;
            ST_ADD:    state_d = ST_WR_LO;
            ST_WR_LO:  state_d = ST_WR_HI;
            ST_WR_HI:  state_d = ST_NEXT;
            ST_NEXT:   state_d = last_i ? ST_IDLE : ST_RD_LO;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: decode the control word and the memory strobes from the state.
    always_comb begin
        ctrl_o           = '0;
        ctrl_o.wsel      = WD_ZERO;
        ctrl_o.clr_cnt   = accept;
        ctrl_o.latch_exp = accept;
        ctrl_o.inc_cnt   = (state_q == ST_NEXT);
        ctrl_o.cap_lo    = (state_q == ST_RD_HI);
        ctrl_o.cap_hi    = (state_q == ST_ROM_RD);
        ctrl_o.cap_add   = (state_q == ST_ADD);
        ctrl_o.sel_hi    = (state_q == ST_CLR_HI) || (state_q == ST_RD_HI)
                        || (state_q == ST_WR_HI);
        if (state_q == ST_WR_LO) ctrl_o.wsel = WD_LO;
        if (state_q == ST_WR_HI) ctrl_o.wsel = WD_HI;
        rom_rd_o = (state_q == ST_ROM_RD);
        ram_rd_o = (state_q == ST_RD_LO) || (state_q == ST_RD_HI);
        ram_wr_o = (state_q == ST_CLR_LO) || (state_q == ST_CLR_HI)
                || (state_q == ST_WR_LO) || (state_q == ST_WR_HI);
    end

    // Purpose: result flags, cleared on an accepted start and set at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            mism_q <= 1'b0;
        end else if (accept) begin
            done_q <= 1'b0;
            mism_q <= 1'b0;
        end else if ((state_q == ST_NEXT) && last_i) begin
            done_q <= 1'b1;
            mism_q <= sum_neq_i;
        end
    end

    assign state_o    = state_q;
    assign busy_o     = (state_q != ST_IDLE);
    assign done_o     = done_q;
    assign mismatch_o = mism_q;

    // R1: reset leaves the engine idle with both flags low
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!busy_o && !done_o && !mismatch_o));

    // R6: done and busy are never high together
    a_r6_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R6: done is held until a start arrives
    a_r6_done_held: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // R6: mismatch is held while idle without a start
    a_r6_mismatch_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(mismatch_o));

    // R7: a start during a run never restarts the clear step
    a_r7_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (state_q != ST_CLR_LO));

    // R8: an accepted start clears both flags
    a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (!done_o && !mismatch_o));

endmodule

// File: rtl/rom_csum_engine.sv
// ROM checksum engine, top level. It connects the table counter, the
// sequencer and the sum datapath, and maps the selected sum byte onto its
// RAM address.
// Assumes: the external ROM and RAM answer a read strobe with data on the
// next cycle, and SUM_BASE+1 fits in RAM_AW bits.
module rom_csum_engine
    import rcs_pkg::*;
#(
    parameter int ROM_AW   = 13,
    parameter int ROM_DW   = 14,
    parameter int RAM_AW   = 8,
    parameter int RAM_DW   = 8,
    parameter int SUM_BASE = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [2*RAM_DW-1:0] expect_sig_i,
    output logic [ROM_AW-1:0]   rom_addr_o,
    output logic                rom_rd_o,
    input  logic [ROM_DW-1:0]   rom_data_i,
    output logic [RAM_AW-1:0]   ram_addr_o,
    output logic                ram_rd_o,
    output logic                ram_wr_o,
    output logic [RAM_DW-1:0]   ram_wdata_o,
    input  logic [RAM_DW-1:0]   ram_rdata_i,
    output logic                busy_o,
    output logic                done_o,
    output logic                mismatch_o
);

    localparam logic [RAM_AW-1:0] ADDR_LO = RAM_AW'(SUM_BASE);
    localparam logic [RAM_AW-1:0] ADDR_HI = RAM_AW'(SUM_BASE + 1);

    rcs_state_e state;
    rcs_ctrl_t  ctrl;
    logic       last;
    logic       sum_neq;

    rcs_table_counter #(.AW(ROM_AW)) u_tcnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (ctrl.clr_cnt),
        .inc_i  (ctrl.inc_cnt),
        .cnt_o  (rom_addr_o),
        .last_o (last)
    );

    rcs_seq_fsm u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .last_i     (last),
        .sum_neq_i  (sum_neq),
        .state_o    (state),
        .ctrl_o     (ctrl),
        .rom_rd_o   (rom_rd_o),
        .ram_rd_o   (ram_rd_o),
        .ram_wr_o   (ram_wr_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .mismatch_o (mismatch_o)
    );

    rcs_sum_datapath #(.ROM_DW(ROM_DW), .RAM_DW(RAM_DW)) u_dp (
        .clk          (clk),
        .rst_n        (rst_n),
        .ctrl_i       (ctrl),
        .ram_rdata_i  (ram_rdata_i),
        .rom_data_i   (rom_data_i),
        .expect_sig_i (expect_sig_i),
        .wdata_o      (ram_wdata_o),
        .sum_neq_o    (sum_neq)
    );

    // Purpose: map the byte select onto its RAM address.
    always_comb begin
        ram_addr_o = ctrl.sel_hi ? ADDR_HI : ADDR_LO;
    end

    // R2: the ROM address is held while the read data returns
    a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |=> $stable(rom_addr_o));

    // R4: every ROM read directly follows a RAM read
    a_r4_rom_after_ram: assert property (@(posedge clk) disable iff (!rst_n)
        rom_rd_o |-> $past(ram_rd_o));

    // R5: the first busy cycle writes a zero
    a_r5_clear_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (ram_wr_o && (ram_wdata_o == '0) && (ram_addr_o == ADDR_LO)));

    // R9: RAM read and write never share a cycle
    a_r9_no_rw_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_rd_o && ram_wr_o));

    // R9: writes land only on the two sum bytes
    a_r9_write_window: assert property (@(posedge clk) disable iff (!rst_n)
        ram_wr_o |-> ((ram_addr_o == ADDR_LO) || (ram_addr_o == ADDR_HI)));

    // R10: each run starts reading at ROM address zero
    a_r10_run_from_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (rom_addr_o == '0));

endmodule

// File: tb/rom_csum_engine_bench.sv
module rom_csum_engine_bench;

    localparam int ROM_AW = 6;
    localparam int ROM_DW = 14;
    localparam int RAM_AW = 8;
    localparam int RAM_DW = 8;
    localparam int BASE   = 16;
    localparam int NW     = 1 << ROM_AW;
    localparam int RUN_CY = 2 + 7 * NW;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start_i = 1'b0;
    logic [15:0]         expect_sig_i = '0;
    logic [ROM_AW-1:0]   rom_addr_o;
    logic                rom_rd_o;
    logic [ROM_DW-1:0]   rom_data_i = '0;
    logic [RAM_AW-1:0]   ram_addr_o;
    logic                ram_rd_o;
    logic                ram_wr_o;
    logic [RAM_DW-1:0]   ram_wdata_o;
    logic [RAM_DW-1:0]   ram_rdata_i = '0;
    logic                busy_o;
    logic                done_o;
    logic                mismatch_o;

    logic [ROM_DW-1:0] rom_mem [0:NW-1];
    logic [RAM_DW-1:0] ram_mem [0:(1<<RAM_AW)-1];

    int checks = 0;
    int errors = 0;

    // monitor state, reset before each run
    int          busy_cnt, rom_idx, widx, addr_err, part_err, clr_err, rw_err;
    logic [15:0] psum;
    logic [7:0]  lo_seen;

    always #5 clk = ~clk;

    rom_csum_engine #(
        .ROM_AW(ROM_AW), .ROM_DW(ROM_DW), .RAM_AW(RAM_AW),
        .RAM_DW(RAM_DW), .SUM_BASE(BASE)
    ) u_rom_csum_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .expect_sig_i(expect_sig_i),
        .rom_addr_o(rom_addr_o), .rom_rd_o(rom_rd_o), .rom_data_i(rom_data_i),
        .ram_addr_o(ram_addr_o), .ram_rd_o(ram_rd_o), .ram_wr_o(ram_wr_o),
        .ram_wdata_o(ram_wdata_o), .ram_rdata_i(ram_rdata_i),
        .busy_o(busy_o), .done_o(done_o), .mismatch_o(mismatch_o)
    );

    // memory models with one-cycle read latency
    always @(posedge clk) begin
        if (rom_rd_o) rom_data_i <= rom_mem[rom_addr_o];
        if (ram_rd_o) ram_rdata_i <= ram_mem[ram_addr_o];
        if (ram_wr_o) ram_mem[ram_addr_o] <= ram_wdata_o;
    end

    // port monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy_o) busy_cnt++;
            if (rom_rd_o) begin
                if (int'(rom_addr_o) != rom_idx) addr_err++;
                rom_idx++;
            end
            if (ram_rd_o && ram_wr_o) rw_err++;
            if (ram_wr_o) begin
                if (widx < 2) begin
                    if (int'(ram_addr_o) != BASE + widx || ram_wdata_o != 8'h00 || rom_idx != 0)
                        clr_err++;
                end else if (widx % 2 == 0) begin
                    if (int'(ram_addr_o) != BASE) part_err++;
                    lo_seen = ram_wdata_o;
                end else begin
                    if ((widx - 2) / 2 < NW)
                        psum = psum + {2'b00, rom_mem[(widx - 2) / 2]};
                    if (int'(ram_addr_o) != BASE + 1 || {ram_wdata_o, lo_seen} != psum)
                        part_err++;
                end
                widx++;
            end
        end
    end

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [15:0] rom_sum();
        logic [15:0] s = '0;
        for (int i = 0; i < NW; i++) s = s + {2'b00, rom_mem[i]};
        return s;
    endfunction

    function automatic void fill_rom(input int mode);
        for (int i = 0; i < NW; i++) begin
            case (mode)
                0: rom_mem[i] = ROM_DW'($urandom);
                1: rom_mem[i] = '1;
                default: rom_mem[i] = '0;
            endcase
        end
    endfunction

    // one run: exp_start at start, optional poke of start and signature mid-run
    task automatic run(input logic [15:0] exp_start, input int poke_at,
                       input logic [15:0] exp_mid);
        int cyc = 0;
        logic [15:0] gold;
        ram_mem[BASE]     = 8'($urandom);
        ram_mem[BASE + 1] = 8'($urandom);
        busy_cnt = 0; rom_idx = 0; widx = 0; addr_err = 0;
        part_err = 0; clr_err = 0; rw_err = 0; psum = '0; lo_seen = '0;
        gold = rom_sum();
        @(negedge clk);
        start_i = 1'b1;
        expect_sig_i = exp_start;
        @(negedge clk);
        start_i = 1'b0;
        chk("R8 flags cleared after start", {30'd0, done_o, mismatch_o}, 32'd0);
        while (!done_o && cyc < RUN_CY + 50) begin
            @(negedge clk);
            cyc++;
            start_i = (cyc == poke_at);
            if (cyc == poke_at) expect_sig_i = exp_mid;
        end
        start_i = 1'b0;
        chk("R6 done raised (watchdog on run)", {31'd0, done_o}, 32'd1);
        chk("R6 busy low with done", {31'd0, busy_o}, 32'd0);
        chk("R6 mismatch vs captured signature", {31'd0, mismatch_o},
            {31'd0, (gold != exp_start)});
        chk("R3 low sum byte in RAM", {24'd0, ram_mem[BASE]}, {24'd0, gold[7:0]});
        chk("R3 high sum byte in RAM", {24'd0, ram_mem[BASE + 1]}, {24'd0, gold[15:8]});
        chk("R3 running sum errors", part_err, 0);
        chk("R4 busy cycle count", busy_cnt, RUN_CY);
        chk("R2 ROM read count", rom_idx, NW);
        chk("R2 R10 ROM address order errors", addr_err, 0);
        chk("R5 zero clear errors", clr_err, 0);
        chk("R9 write count", widx, 2 + 2 * NW);
        chk("R9 read/write overlap", rw_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] g;
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1 << RAM_AW); i++) ram_mem[i] = '0;
        fill_rom(2);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 reset outputs",
            {26'd0, busy_o, done_o, mismatch_o, rom_rd_o, ram_rd_o, ram_wr_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset release", {30'd0, busy_o, done_o}, 32'd0);

        // random ROM, correct signature
        fill_rom(0);
        run(rom_sum(), -1, 16'h0);
        // random ROM, wrong signature, then hold check
        fill_rom(0);
        g = rom_sum();
        run(g ^ 16'h0101, -1, 16'h0);
        repeat (25) @(negedge clk);
        chk("R6 flags held while idle", {30'd0, done_o, mismatch_o}, 32'd3);
        // all-ones ROM: sum wraps modulo 2^16
        fill_rom(1);
        chk("R3 wrap corner value", {16'd0, rom_sum()}, 32'h0000FFC0);
        run(16'hFFC0, -1, 16'h0);
        // all-zero ROM over garbage RAM: R5 clear
        fill_rom(2);
        run(16'h0000, -1, 16'h0);
        // R7 start mid-run ignored; signature change mid-run ignored (R6)
        fill_rom(0);
        g = rom_sum();
        run(g, 100, ~g);
        // constrained random runs
        for (int r = 0; r < 5; r++) begin
            fill_rom(0);
            g = rom_sum();
            if ($urandom % 2 == 0) run(g, 1 + int'($urandom % (RUN_CY - 4)), g);
            else run(g ^ (16'($urandom) | 16'h0001), -1, 16'h0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule